// File: doc/BRIEF.md
# Single-Beat Bus Initiator with Completion Classification

This block acts as the initiator for one bus transaction at a time on a shared parallel bus in the PCI style. A request carries an address, a 4-bit command, byte enables and write data. It is taken over a valid/ready handshake. The engine then drives one address/command cycle and one data phase. During the data phase it watches the target's device-select, target-ready and stop lines and the two error lines. All bus lines are modelled as active-low logic signals.

Every request ends with a one-cycle completion pulse and an 8-bit status code. The code says how the transaction ended. Normal endings (success, retry, disconnect, target abort) get their own codes. Target protocol violations, timeouts and error-line reports also get their own codes. Read data is returned only on success. Requests that the engine cannot carry out are refused at once and never reach the bus.

Top module: `xact_initiator`

## Requirements
- R1: An accepted request holds `frame_no` low for exactly one cycle, with the address on `ad_o` and the command on `cbe_no`. The next cycle starts the data phase with `irdy_no` low. A read that sees device-select and target-ready together completes with status 0, and `rdata_o` holds the value sampled on `ad_i` in that cycle.
- R2: In a write, the data phase drives `wdata` on `ad_o` with `ad_oe_o` high and the inverted byte enables on `cbe_no`. A write that sees device-select and target-ready completes with status 0.
- R3: Status 12 is returned one cycle after acceptance, with no bus activity, when the command is anything other than 0x2, 0x3, 0x6, 0x7, 0xA or 0xB, or when address bits [1:0] are not zero.
- R4: If device-select has never been seen for DEVSEL_TO data-phase cycles (default 5), the request ends with status 1 after exactly DEVSEL_TO data cycles. Device-select that first appears in data cycle DEVSEL_TO-1 is still accepted.
- R5: If device-select goes away after it was asserted, without stop and before target-ready, the request ends with status 2.
- R6: Target-ready without device-select gives status 3. Stop and target-ready together without device-select give status 5.
- R7: If device-select is held for TRDY_TO cycles (default 16) with neither target-ready nor stop, the request ends with status 4.
- R8: Stop with device-select and without target-ready gives status 7 (retry). Stop with device-select and target-ready gives status 8 (disconnect).
- R9: Stop seen with device-select inactive, after device-select had been asserted, gives status 6 (target abort).
- R10: The system-error line gives status 10 and wins over everything else. The parity-error line gives status 11. Stop seen before device-select was ever asserted gives status 14.
- R11: `rdata_o` is zero on every completion whose status is not 0, and on every write.
- R12: After reset, `req_ready_o` is high, the bus is idle and `status_o` is 0. While a request is in flight, `status_o` reads 0xFF and `req_ready_o` is low. `done_o` is high for exactly one cycle per completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request taken this cycle |
| req_addr_i | input | DW | Request address, 4-byte aligned |
| req_cmd_i | input | 4 | Bus command |
| req_be_i | input | DW/8 | Byte enables, active high |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Completion code, 0xFF while in flight |
| rdata_o | output | DW | Read data, zero unless status 0 |
| frame_no | output | 1 | Address-phase strobe, active low |
| irdy_no | output | 1 | Initiator ready, active low |
| cbe_no | output | DW/8 | Command in address phase, byte enables (active low) in data phase |
| ad_o | output | DW | Address/data driven by the engine |
| ad_oe_o | output | 1 | Engine drives the address/data lines |
| ad_i | input | DW | Address/data from the target |
| devsel_ni | input | 1 | Device-select from target, active low |
| trdy_ni | input | 1 | Target ready, active low |
| stop_ni | input | 1 | Target stop, active low |
| serr_ni | input | 1 | System error, active low |
| perr_ni | input | 1 | Parity error, active low |

## Verification
A bench-side target answers each request with device-select, target-ready and stop placed at chosen data-cycle offsets. The same engine code path is therefore exercised by fast, slow and absent responders. Device-select at the last allowed cycle is set against device-select that never arrives, which shows where the decode timeout boundary lies. Dropped device-select with and without stop separates a lost target from a target abort. Stop with and without target-ready, and with and without device-select, separates retry, disconnect, status 5 and status 14. The data-cycle count of each completion is checked against the expected timeout lengths.

// File: rtl/xi_pkg.sv
package xi_pkg;
  typedef enum logic [7:0] {
    ST_OK                  = 8'd0,
    ST_NO_DEVSEL           = 8'd1,
    ST_DEVSEL_LOST         = 8'd2,
    ST_TRDY_NO_DEVSEL      = 8'd3,
    ST_TRDY_TIMEOUT        = 8'd4,
    ST_STOP_TRDY_NO_DEVSEL = 8'd5,
    ST_TGT_ABORT           = 8'd6,
    ST_RETRY               = 8'd7,
    ST_DISCONNECT          = 8'd8,
    ST_SERR                = 8'd10,
    ST_PERR                = 8'd11,
    ST_MALFORMED           = 8'd12,
    ST_GENERAL             = 8'd14,
    ST_PENDING             = 8'hFF
  } xi_status_e;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} xi_state_e;
endpackage

// File: rtl/xi_req_check.sv
module xi_req_check #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] addr_i,
  input  logic [3:0]    cmd_i,
  output logic          ok_o
);
  logic cmd_ok;
  always_comb begin
    unique case (cmd_i)
      4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB: cmd_ok = 1'b1;
      default:                            cmd_ok = 1'b0;
    endcase
  end
  assign ok_o = cmd_ok && (addr_i[1:0] == 2'b00);
endmodule

// File: rtl/xi_wait_timer.sv
module xi_wait_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (en_i && (cnt_q != LAST))  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/xi_term_decode.sv
module xi_term_decode
  import xi_pkg::*;
(
  input  logic       active_i,
  input  logic       dev_i,
  input  logic       trdy_i,
  input  logic       stop_i,
  input  logic       serr_i,
  input  logic       perr_i,
  input  logic       dev_seen_i,
  input  logic       dev_to_i,
  input  logic       trdy_to_i,
  output logic       fin_o,
  output xi_status_e code_o
);
  logic fin;
  always_comb begin
    fin    = 1'b1;
    code_o = ST_GENERAL;
    if (serr_i)      code_o = ST_SERR;
    else if (perr_i) code_o = ST_PERR;
    else if (dev_i) begin
      if (stop_i && trdy_i) code_o = ST_DISCONNECT;
      else if (stop_i)      code_o = ST_RETRY;
      else if (trdy_i)      code_o = ST_OK;
      else if (trdy_to_i)   code_o = ST_TRDY_TIMEOUT;
      else                  fin = 1'b0;
    end else begin
      if (stop_i && trdy_i)         code_o = ST_STOP_TRDY_NO_DEVSEL;
      else if (trdy_i)              code_o = ST_TRDY_NO_DEVSEL;
      else if (stop_i && dev_seen_i) code_o = ST_TGT_ABORT;
      else if (stop_i)              code_o = ST_GENERAL;  // stop from a target never selected
      else if (dev_seen_i)          code_o = ST_DEVSEL_LOST;
      else if (dev_to_i)            code_o = ST_NO_DEVSEL;
      else                          fin = 1'b0;
    end
  end
  assign fin_o = active_i && fin;
endmodule

// File: rtl/xact_initiator.sv
module xact_initiator
  import xi_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEVSEL_TO = 5,
  parameter int TRDY_TO   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [DW-1:0]   req_addr_i,
  input  logic [3:0]      req_cmd_i,
  input  logic [DW/8-1:0] req_be_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            done_o,
  output logic [7:0]      status_o,
  output logic [DW-1:0]   rdata_o,
  output logic            frame_no,
  output logic            irdy_no,
  output logic [DW/8-1:0] cbe_no,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  input  logic [DW-1:0]   ad_i,
  input  logic            devsel_ni,
  input  logic            trdy_ni,
  input  logic            stop_ni,
  input  logic            serr_ni,
  input  logic            perr_ni
);
  localparam int BEW = DW / 8;

  xi_state_e       state_q;
  logic [DW-1:0]   addr_q, wdata_q, rdata_q;
  logic [3:0]      cmd_q;
  logic [BEW-1:0]  be_q;
  logic            dev_seen_q, done_q;
  xi_status_e      status_q;

  logic req_ok, in_data, dev, dev_to, trdy_to, fin;
  xi_status_e code;

  assign in_data = (state_q == S_DATA);
  assign dev     = !devsel_ni;

  xi_req_check #(.DW(DW)) u_req_check (
    .addr_i (req_addr_i),
    .cmd_i  (req_cmd_i),
    .ok_o   (req_ok)
  );

  xi_wait_timer #(.LIMIT(DEVSEL_TO)) u_dev_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_data),
    .en_i   (in_data && !dev_seen_q && !dev),
    .hit_o  (dev_to)
  );

  xi_wait_timer #(.LIMIT(TRDY_TO)) u_trdy_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_data),
    .en_i   (in_data && dev),
    .hit_o  (trdy_to)
  );

  xi_term_decode u_term (
    .active_i   (in_data),
    .dev_i      (dev),
    .trdy_i     (!trdy_ni),
    .stop_i     (!stop_ni),
    .serr_i     (!serr_ni),
    .perr_i     (!perr_ni),
    .dev_seen_i (dev_seen_q),
    .dev_to_i   (dev_to),
    .trdy_to_i  (trdy_to),
    .fin_o      (fin),
    .code_o     (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      cmd_q      <= '0;
      be_q       <= '0;
      dev_seen_q <= 1'b0;
      done_q     <= 1'b0;
      status_q   <= ST_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            if (req_ok) begin
              addr_q     <= req_addr_i;
              cmd_q      <= req_cmd_i;
              be_q       <= req_be_i;
              wdata_q    <= req_wdata_i;
              dev_seen_q <= 1'b0;
              status_q   <= ST_PENDING;
              state_q    <= S_ADDR;
            end else begin
              done_q   <= 1'b1;
              status_q <= ST_MALFORMED;
              rdata_q  <= '0;
            end
          end
        end
        S_ADDR: state_q <= S_DATA;
        S_DATA: begin
          if (dev) dev_seen_q <= 1'b1;
          if (fin) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= code;
            // cmd bit 0 set marks a write
            rdata_q  <= (code == ST_OK && !cmd_q[0]) ? ad_i : '0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    frame_no = 1'b1;
    irdy_no  = 1'b1;
    cbe_no   = '1;
    ad_o     = '0;
    ad_oe_o  = 1'b0;
    unique case (state_q)
      S_ADDR: begin
        frame_no = 1'b0;
        cbe_no   = BEW'(cmd_q);
        ad_o     = addr_q;
        ad_oe_o  = 1'b1;
      end
      S_DATA: begin
        irdy_no = 1'b0;
        cbe_no  = ~be_q;
        ad_o    = cmd_q[0] ? wdata_q : '0;
        ad_oe_o = cmd_q[0];
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = done_q;
  assign status_o    = status_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/xact_initiator_chk.sv
module xact_initiator_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [DW-1:0] req_addr_i,
  input logic [3:0]    req_cmd_i,
  input logic          done_o,
  input logic [7:0]    status_o,
  input logic [DW-1:0] rdata_o,
  input logic          frame_no,
  input logic          irdy_no
);
  logic bad_req;
  assign bad_req = !(req_cmd_i inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB}) ||
                   (req_addr_i[1:0] != 2'b00);

  AST_SINGLE_ADDR_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_no |=> frame_no && !irdy_no);  // R1

  AST_MALFORMED_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && bad_req |=> done_o && status_o == 8'd12 && frame_no);  // R3

  AST_ZERO_RDATA_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o != 8'd0 |-> rdata_o == '0);  // R11

  AST_PENDING_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> status_o == 8'hFF && !done_o);  // R12

  AST_DONE_ENDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irdy_no) |-> done_o && req_ready_o);  // R12
endmodule

bind xact_initiator xact_initiator_chk #(.DW(DW)) u_xact_initiator_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .req_cmd_i   (req_cmd_i),
  .done_o      (done_o),
  .status_o    (status_o),
  .rdata_o     (rdata_o),
  .frame_no    (frame_no),
  .irdy_no     (irdy_no)
);

// File: tb/xact_initiator_test.sv
module xact_initiator_test;
  localparam int DW = 32;
  localparam logic [31:0] RD_PAT = 32'hA5C3_1E70;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [31:0]   req_addr = '0, req_wdata = '0;
  logic [3:0]    req_cmd = '0, req_be = '0;
  logic          done;
  logic [7:0]    status;
  logic [31:0]   rdata, ad_out, ad_in = '0;
  logic          frame_n, irdy_n, ad_oe;
  logic [3:0]    cbe_n;
  logic          devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, serr_n = 1'b1, perr_n = 1'b1;

  xact_initiator #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_cmd_i(req_cmd), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .done_o(done), .status_o(status), .rdata_o(rdata),
    .frame_no(frame_n), .irdy_no(irdy_n), .cbe_no(cbe_n), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ad_i(ad_in), .devsel_ni(devsel_n), .trdy_ni(trdy_n), .stop_ni(stop_n),
    .serr_ni(serr_n), .perr_ni(perr_n)
  );

  int checks = 0, errors = 0;
  // target response plan, in data-cycle offsets (-1 = never)
  int dev_at = -1, drop_at = -1, trdy_at = -1, stop_at = -1, serr_at = -1, perr_at = -1;
  int idx = 0;

  function automatic bit hit(int at, int i);
    return (at >= 0) && (i >= at);
  endfunction

  always @(negedge clk) begin
    if (!irdy_n) begin
      devsel_n <= !(hit(dev_at, idx) && !hit(drop_at, idx));
      trdy_n   <= !hit(trdy_at, idx);
      stop_n   <= !hit(stop_at, idx);
      serr_n   <= !hit(serr_at, idx);
      perr_n   <= !hit(perr_at, idx);
      ad_in    <= hit(trdy_at, idx) ? RD_PAT : 32'h0;
      idx      <= idx + 1;
    end else begin
      idx <= 0;
      devsel_n <= 1'b1; trdy_n <= 1'b1; stop_n <= 1'b1;
      serr_n <= 1'b1; perr_n <= 1'b1; ad_in <= '0;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic plan(int d, int dr, int t, int s, int se, int pe);
    dev_at = d; drop_at = dr; trdy_at = t; stop_at = s; serr_at = se; perr_at = pe;
  endtask

  task automatic run_xact(string tag, logic [3:0] cmd, logic [31:0] addr, logic [3:0] be,
                          logic [31:0] wd, logic [7:0] exp_st, logic [31:0] exp_rd, int exp_cyc);
    int cyc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!frame_n && ad_out == addr && cbe_n == cmd && status == 8'hFF && !req_ready,
          {tag, " addr phase"}, {frame_n, cbe_n, status, ad_out[14:0]}, {1'b0, cmd, 8'hFF, addr[14:0]});
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done) break;
      if (cyc == 0 && cmd[0])
        check(ad_oe && ad_out == wd && cbe_n == ~be && !irdy_n, "R2 write data phase",
              {ad_oe, cbe_n, ad_out[26:0]}, {1'b1, ~be, wd[26:0]});
      cyc++;
    end
    check(done && status == exp_st, {tag, " status"}, {23'd0, done, status}, {23'd0, 1'b1, exp_st});
    check(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
    check(cyc == exp_cyc, {tag, " data cycles"}, cyc, exp_cyc);
    @(negedge clk);
    check(!done && req_ready, "R12 done pulse single", {done, req_ready}, 2'b01);
  endtask

  task automatic run_malformed(string tag, logic [3:0] cmd, logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    check(done && status == 8'd12 && frame_n && irdy_n && rdata == 0, tag,
          {done, frame_n, status}, {2'b11, 8'd12});
    @(negedge clk);
    check(!done && frame_n, {tag, " no bus"}, {done, frame_n}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && frame_n && irdy_n && status == 0 && !done, "R12 reset state",
          {req_ready, frame_n, irdy_n, done, status}, {4'b1110, 8'd0});
    rst_n = 1'b1;

    // R1 memory read, devsel at 1, trdy at 2
    plan(1, -1, 2, -1, -1, -1);
    run_xact("R1 mem read", 4'h6, 32'h1000_0040, 4'hF, 0, 8'd0, RD_PAT, 3);
    // R1 config read, slow target
    plan(2, -1, 4, -1, -1, -1);
    run_xact("R1 cfg read", 4'hA, 32'h0000_0104, 4'hF, 0, 8'd0, RD_PAT, 5);
    // R2 io write, fast target, R11 write returns zero
    plan(0, -1, 0, -1, -1, -1);
    run_xact("R2 io write", 4'h3, 32'h0000_0C80, 4'b0011, 32'h1234_ABCD, 8'd0, 0, 1);
    // R3 refused requests
    run_malformed("R3 cmd 0xC", 4'hC, 32'h0000_1000);
    run_malformed("R3 cmd 0x0", 4'h0, 32'h0000_1000);
    run_malformed("R3 misaligned", 4'h7, 32'h0000_1002);
    // R4 no devsel, and devsel at last allowed cycle
    plan(-1, -1, -1, -1, -1, -1);
    run_xact("R4 no devsel", 4'h6, 32'h2000_0000, 4'hF, 0, 8'd1, 0, 5);
    plan(4, -1, 4, -1, -1, -1);
    run_xact("R4 devsel at limit", 4'h6, 32'h2000_0010, 4'hF, 0, 8'd0, RD_PAT, 5);
    // R5 devsel lost
    plan(0, 2, -1, -1, -1, -1);
    run_xact("R5 devsel lost", 4'h6, 32'h2000_0020, 4'hF, 0, 8'd2, 0, 3);
    // R6 trdy without devsel; stop+trdy without devsel
    plan(-1, -1, 1, -1, -1, -1);
    run_xact("R6 trdy no devsel", 4'h6, 32'h2000_0030, 4'hF, 0, 8'd3, 0, 2);
    plan(-1, -1, 1, 1, -1, -1);
    run_xact("R6 stop trdy no devsel", 4'h7, 32'h2000_0034, 4'hF, 32'h55, 8'd5, 0, 2);
    // R7 trdy timeout: devsel from cycle 1, 16 waiting cycles
    plan(1, -1, -1, -1, -1, -1);
    run_xact("R7 trdy timeout", 4'h6, 32'h2000_0040, 4'hF, 0, 8'd4, 0, 17);
    // R8 retry and disconnect (R11 disconnect read data zero)
    plan(0, -1, -1, 1, -1, -1);
    run_xact("R8 retry", 4'h6, 32'h2000_0050, 4'hF, 0, 8'd7, 0, 2);
    plan(0, -1, 1, 1, -1, -1);
    run_xact("R8 R11 disconnect", 4'h6, 32'h2000_0054, 4'hF, 0, 8'd8, 0, 2);
    // R9 target abort
    plan(0, 2, -1, 2, -1, -1);
    run_xact("R9 target abort", 4'h7, 32'h2000_0060, 4'hF, 32'h77, 8'd6, 0, 3);
    // R10 serr over trdy, perr, stray stop
    plan(0, -1, 1, -1, 1, -1);
    run_xact("R10 serr", 4'h6, 32'h2000_0070, 4'hF, 0, 8'd10, 0, 2);
    plan(0, -1, -1, -1, -1, 1);
    run_xact("R10 perr", 4'h6, 32'h2000_0074, 4'hF, 0, 8'd11, 0, 2);
    plan(-1, -1, -1, 0, -1, -1);
    run_xact("R10 stop unselected", 4'h6, 32'h2000_0078, 4'hF, 0, 8'd14, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule